// File: doc/BRIEF.md
# Debug Trigger Match and Chain Unit

This block holds ten hardware debug triggers and checks each one against the current instruction fetch, load and store events. Every trigger watches one fixed kind of event. It compares that event's address with its own 64-bit compare value, using one of four comparison modes. The triggers are paired into five fixed groups. A group can be chained so that its two members fire only together.

Software programs one trigger at a time through a write port. Each write carries an index and a full descriptor: enable, match type, select, timing, action, chain and compare value. The event inputs are compared without any register stage. The results appear in the same cycle as raw per-trigger hits, chained fire results, and the timing and action bits of the triggers that fire. A single flag shows whether anything fired.

Trigger kinds by index:
- Indices 0, 1, 6 and 8 watch fetch.
- Indices 2, 3 and 7 watch store.
- Indices 4, 5 and 9 watch load.

Group g is the pair of triggers 2g and 2g+1.

Top module: `trig_match_unit`

## Requirements
- R1: A configuration write with `cfg_we` high and `cfg_idx` below 10 updates that trigger's descriptor at the clock edge, so the change shows on the outputs from the following cycle. A write with an index of 10 or above changes nothing.
- R2: After reset every trigger is disabled and every chain bit is clear, so `raw_hit`, `fire`, `fire_timing`, `fire_action` and `any_hit` are all zero whatever the events.
- R3: A trigger produces a raw hit only when it is enabled, the event of its kind is valid, and the address comparison succeeds. The kinds are fetch for indices 0, 1, 6 and 8, store for 2, 3 and 7, and load for 4, 5 and 9.
- R4: The 2-bit match type selects the comparison between event address A and compare value V:
  - 0: A == V
  - 1: A >= V (unsigned)
  - 2: A < V (unsigned)
  - 3: masked match. With M = V ^ (V+1), the trigger matches when (A|M) == (V|M).
- R5: A load trigger with its select bit set never matches. The select bit has no effect on fetch and store triggers.
- R6: A trigger in an unchained group fires exactly when it has a raw hit.
- R7: Group g is chained when the chain bit of trigger 2g is set; the chain bit of trigger 2g+1 is not used. In a chained group both members fire when both have raw hits and equal timing bits. In every other case neither member fires.
- R8: Group 1 (store/store) is never chained. Its members fire on their own raw hits whatever their chain bits hold.
- R9: `fire_timing` bit k equals trigger k's timing bit when trigger k fires, and is zero otherwise. Timing 0 means trap on the current instruction; timing 1 means trap on the next one.
- R10: `fire_action` bit k equals trigger k's action bit when trigger k fires, and is zero otherwise.
- R11: `any_hit` is high exactly when at least one trigger fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Index of the trigger to write |
| cfg_enable | input | 1 | Trigger enable |
| cfg_mtype | input | 2 | Match type |
| cfg_sel | input | 1 | Select bit (data compare on load, never matches) |
| cfg_timing | input | 1 | Timing bit |
| cfg_action | input | 1 | Action bit |
| cfg_chain | input | 1 | Chain bit (used on even triggers) |
| cfg_value | input | ADDR_W | Compare value |
| fetch_valid | input | 1 | Fetch event valid |
| fetch_pc | input | ADDR_W | Fetch address |
| load_valid | input | 1 | Load event valid |
| load_addr | input | ADDR_W | Load address |
| store_valid | input | 1 | Store event valid |
| store_addr | input | ADDR_W | Store address |
| raw_hit | output | 10 | Per-trigger match before chaining |
| fire | output | 10 | Per-trigger fire after chaining |
| fire_timing | output | 10 | Timing bit of each firing trigger |
| fire_action | output | 10 | Action bit of each firing trigger |
| any_hit | output | 1 | At least one trigger fires |

## Verification
The assertions hold on every cycle for the following properties:
- A fire never appears without a raw hit.
- A raw hit never appears on a disabled trigger or on an event kind that is not valid.
- A load trigger with select set never hits.
- The store/store pair always fires on its own hits.
- A chained pair whose timing bits differ stays silent.
- The timing and action outputs stay within the fire vector.

Some behaviour can only be shown by the bench's scenarios against its own reference model:
- the exact arithmetic of the four comparison modes;
- the one-cycle delay of configuration writes and the dropping of writes to indices 10 and above;
- the rule that a chained pair needs both members to hit.

// File: rtl/trig_match_unit.sv
module trig_match_unit #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mtype,
  input  logic              cfg_sel,
  input  logic              cfg_timing,
  input  logic              cfg_action,
  input  logic              cfg_chain,
  input  logic [ADDR_W-1:0] cfg_value,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  output logic [9:0]        raw_hit,
  output logic [9:0]        fire,
  output logic [9:0]        fire_timing,
  output logic [9:0]        fire_action,
  output logic              any_hit
);
  localparam int NTRIG = 10;
  localparam int NGRP  = NTRIG / 2;

  logic [NTRIG-1:0] en_q, sel_q, tim_q, act_q, chn_q;
  logic [1:0]        mt_q  [NTRIG];
  logic [ADDR_W-1:0] val_q [NTRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      tim_q <= '0;
      act_q <= '0;
      chn_q <= '0;
      for (int k = 0; k < NTRIG; k++) begin
        mt_q[k]  <= '0;
        val_q[k] <= '0;
      end
    end else if (cfg_we && cfg_idx < 4'(NTRIG)) begin
      en_q[cfg_idx]  <= cfg_enable;
      sel_q[cfg_idx] <= cfg_sel;
      tim_q[cfg_idx] <= cfg_timing;
      act_q[cfg_idx] <= cfg_action;
      chn_q[cfg_idx] <= cfg_chain;
      mt_q[cfg_idx]  <= cfg_mtype;
      val_q[cfg_idx] <= cfg_value;
    end
  end

  for (genvar k = 0; k < NTRIG; k++) begin : g_trig
    // 0 fetch, 1 store, 2 load
    localparam int KIND = (k < 2 || k == 6 || k == 8) ? 0 :
                          (k < 4 || k == 7)           ? 1 : 2;
    logic [ADDR_W-1:0] a, v, nm;
    logic              ev, cmp;

    if (KIND == 0) begin : g_f
      assign a = fetch_pc;   assign ev = fetch_valid;
    end else if (KIND == 1) begin : g_s
      assign a = store_addr; assign ev = store_valid;
    end else begin : g_l
      assign a = load_addr;  assign ev = load_valid;
    end

    assign v  = val_q[k];
    assign nm = v ^ (v + 1'b1);

    always_comb begin
      case (mt_q[k])
        2'd0:    cmp = (a == v);
        2'd1:    cmp = (a >= v);
        2'd2:    cmp = (a < v);
        default: cmp = ((a | nm) == (v | nm));
      endcase
    end

    assign raw_hit[k] = en_q[k] & ev & cmp & ~((KIND == 2) & sel_q[k]);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic ch, pair_ok;
    assign ch      = (g != 1) & chn_q[2*g];
    assign pair_ok = raw_hit[2*g] & raw_hit[2*g+1] & (tim_q[2*g] == tim_q[2*g+1]);
    assign fire[2*g]   = ch ? pair_ok : raw_hit[2*g];
    assign fire[2*g+1] = ch ? pair_ok : raw_hit[2*g+1];
  end

  assign fire_timing = fire & tim_q;
  assign fire_action = fire & act_q;
  assign any_hit     = |fire;
endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       load_valid,
  input logic       store_valid,
  input logic [9:0] raw_hit,
  input logic [9:0] fire,
  input logic [9:0] fire_timing,
  input logic [9:0] fire_action,
  input logic [9:0] en_q,
  input logic [9:0] sel_q,
  input logic [9:0] tim_q,
  input logic [9:0] chn_q
);
  localparam logic [9:0] FMASK = 10'b0101000011;
  localparam logic [9:0] SMASK = 10'b0010001100;
  localparam logic [9:0] LMASK = 10'b1000110000;

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && chn_q == '0));

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit & ~en_q) == '0);

  // R3
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (raw_hit & FMASK) == '0);

  // R3
  store_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_valid |-> (raw_hit & SMASK) == '0);

  // R3
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (raw_hit & LMASK) == '0);

  // R5
  load_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit & LMASK & sel_q) == '0);

  // R6
  fire_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & ~raw_hit) == '0);

  // R8
  store_pair_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire[3:2] == raw_hit[3:2]);

  for (genvar g = 0; g < 5; g++) begin : g_chain
    if (g != 1) begin : g_on
      // R7
      chain_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chn_q[2*g] && tim_q[2*g] != tim_q[2*g+1]) |-> fire[2*g+1 -: 2] == 2'b00);
    end
  end

  // R9
  timing_in_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_timing & ~fire) == '0);

  // R10
  action_in_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_action & ~fire) == '0);
endmodule

bind trig_match_unit trig_match_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .fetch_valid(fetch_valid), .load_valid(load_valid), .store_valid(store_valid),
  .raw_hit(raw_hit), .fire(fire), .fire_timing(fire_timing), .fire_action(fire_action),
  .en_q(en_q), .sel_q(sel_q), .tim_q(tim_q), .chn_q(chn_q)
);

// File: tb/trig_match_unit_tb.sv
`timescale 1ns/1ps
module trig_match_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic        cfg_enable = 0, cfg_sel = 0, cfg_timing = 0, cfg_action = 0, cfg_chain = 0;
  logic [1:0]  cfg_mtype = 0;
  logic [63:0] cfg_value = 0;
  logic        fetch_valid = 0, load_valid = 0, store_valid = 0;
  logic [63:0] fetch_pc = 0, load_addr = 0, store_addr = 0;
  logic [9:0]  raw_hit, fire, fire_timing, fire_action;
  logic        any_hit;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the configuration
  bit          m_en[10], m_sel[10], m_tim[10], m_act[10], m_chn[10];
  logic [1:0]  m_mt[10];
  logic [63:0] m_val[10];

  always #2 clk = ~clk;

  trig_match_unit u_dut (.*);

  function automatic int kind_of(int k);
    if (k == 0 || k == 1 || k == 6 || k == 8) return 0;
    if (k == 2 || k == 3 || k == 7) return 1;
    return 2;
  endfunction

  function automatic logic [9:0] exp_raw();
    logic [9:0] r;
    for (int k = 0; k < 10; k++) begin
      logic [63:0] a, v, m;
      logic ev, c;
      case (kind_of(k))
        0: begin a = fetch_pc;   ev = fetch_valid; end
        1: begin a = store_addr; ev = store_valid; end
        default: begin a = load_addr; ev = load_valid; end
      endcase
      v = m_val[k];
      m = v ^ (v + 64'd1);
      case (m_mt[k])
        2'd0: c = (a == v);
        2'd1: c = (a >= v);
        2'd2: c = (a < v);
        default: c = ((a | m) == (v | m));
      endcase
      r[k] = m_en[k] && ev && c && !(kind_of(k) == 2 && m_sel[k]);
    end
    return r;
  endfunction

  function automatic logic [9:0] exp_fire(logic [9:0] r);
    logic [9:0] f;
    for (int g = 0; g < 5; g++) begin
      if (g != 1 && m_chn[2*g]) begin
        logic both;
        both = r[2*g] && r[2*g+1] && (m_tim[2*g] == m_tim[2*g+1]);
        f[2*g] = both; f[2*g+1] = both;
      end else begin
        f[2*g] = r[2*g]; f[2*g+1] = r[2*g+1];
      end
    end
    return f;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic [9:0] r, f, t, a;
    r = exp_raw();
    f = exp_fire(r);
    for (int k = 0; k < 10; k++) begin
      t[k] = f[k] & m_tim[k];
      a[k] = f[k] & m_act[k];
    end
    chk({tag, " R3 R4 raw"}, 64'(raw_hit), 64'(r));
    chk({tag, " R6 R7 fire"}, 64'(fire), 64'(f));
    chk({tag, " R9 timing"}, 64'(fire_timing), 64'(t));
    chk({tag, " R10 action"}, 64'(fire_action), 64'(a));
    chk({tag, " R11 any"}, 64'(any_hit), 64'(|f));
  endtask

  task automatic wr(int idx, bit en, logic [1:0] mt, bit sel, bit tim, bit act, bit chn, logic [63:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_enable = en; cfg_mtype = mt; cfg_sel = sel;
    cfg_timing = tim; cfg_action = act; cfg_chain = chn; cfg_value = val;
    @(posedge clk); #1;
    cfg_we = 0;
    if (idx < 10) begin
      m_en[idx] = en; m_mt[idx] = mt; m_sel[idx] = sel; m_tim[idx] = tim;
      m_act[idx] = act; m_chn[idx] = chn; m_val[idx] = val;
    end
  endtask

  task automatic ev(bit fv, logic [63:0] fa, bit lv, logic [63:0] la, bit sv, logic [63:0] sa);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fa; load_valid = lv; load_addr = la;
    store_valid = sv; store_addr = sa;
    #1;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 10; k++) wr(k, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 10; k++) begin
      m_en[k] = 0; m_sel[k] = 0; m_tim[k] = 0; m_act[k] = 0; m_chn[k] = 0;
      m_mt[k] = 0; m_val[k] = 0;
    end
    fetch_valid = 1; load_valid = 1; store_valid = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    ev(1, 0, 1, 0, 1, 0);
    // R2: all compare values equal the events, yet nothing is enabled
    chk("R2 fire after reset", 64'(fire), 0);
    chk("R2 any after reset", 64'(any_hit), 0);

    // R1: write is visible only after the edge
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 64'h1000;
    cfg_we = 1; cfg_idx = 0; cfg_enable = 1; cfg_mtype = 0; cfg_sel = 0;
    cfg_timing = 1; cfg_action = 1; cfg_chain = 0; cfg_value = 64'h1000;
    #1 chk("R1 before edge", 64'(raw_hit[0]), 0);
    @(posedge clk); #1 cfg_we = 0;
    m_en[0] = 1; m_val[0] = 64'h1000; m_tim[0] = 1; m_act[0] = 1;
    chk("R1 after edge", 64'(raw_hit[0]), 1);
    ev(1, 64'h1000, 0, 0, 0, 0);
    chk_all("eq hit");
    chk("R9 timing t0", 64'(fire_timing[0]), 1);

    // R1: out-of-range index changes nothing
    wr(12, 1, 1, 0, 0, 0, 0, 0);
    wr(15, 0, 0, 0, 0, 0, 0, 0);
    ev(1, 64'h1000, 1, 5, 1, 5);
    chk("R1 idx>=10 ignored", 64'(fire), 64'h1);

    // R3: invalid fetch blocks
    ev(0, 64'h1000, 0, 0, 0, 0);
    chk("R3 invalid event", 64'(raw_hit), 0);

    // R4: the four match types
    wr(1, 1, 1, 0, 0, 0, 0, 64'h2000);
    ev(1, 64'h2000, 0, 0, 0, 0);
    chk("R4 ge equal", 64'(raw_hit[1]), 1);
    ev(1, 64'h1fff, 0, 0, 0, 0);
    chk("R4 ge below", 64'(raw_hit[1]), 0);
    wr(2, 1, 2, 0, 0, 0, 0, 64'h3000);
    ev(0, 0, 0, 0, 1, 64'h2fff);
    chk("R4 lt below", 64'(raw_hit[2]), 1);
    ev(0, 0, 0, 0, 1, 64'h3000);
    chk("R4 lt equal", 64'(raw_hit[2]), 0);
    wr(3, 1, 3, 0, 0, 0, 0, 64'h4003);
    ev(0, 0, 0, 0, 1, 64'h4007);
    chk("R4 mask top", 64'(raw_hit[3]), 1);
    ev(0, 0, 0, 0, 1, 64'h4008);
    chk("R4 mask out", 64'(raw_hit[3]), 0);

    // R5: load select never matches; fetch ignores select
    clear_all();
    wr(4, 1, 0, 1, 0, 0, 0, 64'h50);
    wr(6, 1, 0, 1, 0, 0, 0, 64'h60);
    ev(1, 64'h60, 1, 64'h50, 0, 0);
    chk("R5 load sel", 64'(raw_hit[4]), 0);
    chk("R5 fetch sel ignored", 64'(raw_hit[6]), 1);

    // R7: chained group 0
    clear_all();
    wr(0, 1, 0, 0, 1, 0, 1, 64'h100);
    wr(1, 1, 0, 0, 1, 0, 0, 64'h100);
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R7 both hit", 64'(fire[1:0]), 3);
    wr(1, 1, 0, 0, 1, 0, 0, 64'h104);
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R7 one hit", 64'(fire[1:0]), 0);
    chk("R6 raw still", 64'(raw_hit[1:0]), 1);
    wr(1, 1, 0, 0, 0, 0, 0, 64'h100);
    ev(1, 64'h100, 0, 0, 0, 0);
    chk("R7 timing differs", 64'(fire[1:0]), 0);
    chk("R11 none", 64'(any_hit), 0);

    // R8: store/store chain ignored
    wr(2, 1, 0, 0, 0, 0, 1, 64'h200);
    wr(3, 1, 0, 0, 0, 0, 1, 64'h204);
    ev(0, 0, 0, 0, 1, 64'h200);
    chk("R8 store unchained", 64'(fire[3:2]), 1);

    // R7: mixed fetch/load group 4
    wr(8, 1, 0, 0, 0, 1, 1, 64'h300);
    wr(9, 1, 0, 0, 0, 1, 0, 64'h310);
    ev(1, 64'h300, 1, 64'h310, 0, 0);
    chk("R7 fetch load pair", 64'(fire[9:8]), 3);
    chk("R10 action pair", 64'(fire_action[9:8]), 3);

    // random
    clear_all();
    for (int it = 0; it < 400; it++) begin
      int idx;
      logic [63:0] v;
      idx = $urandom_range(0, 11);
      v = 64'($urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) v = {$urandom, $urandom};
      wr(idx, $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), v);
      for (int j = 0; j < 3; j++) begin
        ev(1'($urandom_range(0, 1)), 64'($urandom_range(0, 70)),
           1'($urandom_range(0, 1)), 64'($urandom_range(0, 70)),
           1'($urandom_range(0, 1)), 64'($urandom_range(0, 70)));
        chk_all("random");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule